// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block produces the external memory strobes of an 8-bit core whose low address byte and data byte share one port. Time is counted in oscillator periods, marked by a one-clock `osc_tick` enable. The block runs back-to-back bus slots of six periods each. In every slot it chooses an idle slot, a code fetch (one slot) or a data read or write (two slots, the second without an address strobe). It then drives the address strobe (ALE), the program-store strobe, the read and write strobes, the shared low port with its drive enable and the high address port, and it captures the byte returned by memory.

The core presents a fetch request or a data request. Each request is held until its acknowledge pulse, which marks the slot boundary at which the request was taken. A quiet-mode input can stop the address strobe in idle slots. The strobe still runs for every access slot, so external latches keep working.

Tick numbers below count oscillator periods from the start of a slot. Tick 0 is the first period after the boundary, and a data access spans ticks 0 to 11.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset, ALE is low, `psen_n`, `rd_n` and `wr_n` are high, the shared port is not driven, and no acknowledge or read-valid pulse is given.
- R2: With `ale_off` low and no request, ALE is high in ticks 0 and 1 of every six-tick slot and low in ticks 2 to 5.
- R3: A code fetch slot drives the low address on `p0_out` with `p0_oe` high in ticks 0 to 2 and raises ALE in ticks 0 and 1. `psen_n` is low in ticks 3 to 5, during which the port is released. The byte on `p0_in` in tick 5 is returned on `rdata` with a one-clock `rdata_vld` pulse.
- R4: A data read (request with `dmem_we` low) lasts 12 ticks. The low address is driven in ticks 0 to 2, `rd_n` is low in ticks 5 to 10, and the port is released in ticks 3 to 11. The byte on `p0_in` in tick 10 is returned with `rdata_vld`.
- R5: A data write (`dmem_we` high) lasts 12 ticks with the port driven throughout. The low address is driven in ticks 0 to 3 and the write byte in ticks 4 to 11, and `wr_n` is low in ticks 5 to 10.
- R6: In ticks 6 to 11 of a data access, the ALE pulse that would otherwise occur is skipped, so ALE stays low.
- R7: When `ale_off` is high at a slot boundary and the slot is idle, ALE stays low for that slot. Fetch and data slots pulse ALE whatever the level of `ale_off`.
- R8: `p2_out` carries the high address byte of the access from tick 0 to its last tick and keeps it until the next access begins.
- R9: `psen_n` stays high during data reads and writes.
- R10: At a slot boundary a pending data request takes priority over a pending fetch request. Exactly one of `dmem_ack` and `fetch_ack` pulses for one clock after the boundary edge, naming the request that was taken.
- R11: On clocks without `osc_tick`, no output changes and no acknowledge or read-valid pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_tick | input | 1 | One-clock enable per oscillator period |
| ale_off | input | 1 | Quiet mode: no ALE in idle slots |
| fetch_req | input | 1 | External code fetch request, held until acknowledged |
| fetch_addr | input | ADDR_W | Code fetch address |
| dmem_req | input | 1 | External data access request, held until acknowledged |
| dmem_we | input | 1 | 1 = write, 0 = read |
| dmem_addr | input | ADDR_W | Data address |
| dmem_wdata | input | DATA_W | Write byte |
| p0_in | input | DATA_W | Value read from the shared port |
| fetch_ack | output | 1 | Fetch request taken at the last boundary |
| dmem_ack | output | 1 | Data request taken at the last boundary |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | DATA_W | Value driven on the shared port |
| p0_oe | output | 1 | Shared port drive enable |
| p2_out | output | ADDR_W-DATA_W | High address port |
| rdata | output | DATA_W | Last captured byte |
| rdata_vld | output | 1 | One-clock pulse when `rdata` is updated |

## Verification
The bench builds the block with its default widths: an 8-bit data and low-address byte and a 16-bit address. Distinct high and low address bytes and arbitrary write bytes can therefore be told apart on `p2_out` and `p0_out`. Runs with a tick on every clock and with a tick on two clocks in three reach both the dense timing and the held outputs between ticks. Back-to-back fetches, mixed reads and writes, simultaneous requests and quiet mode across access boundaries are all driven through the same request handshake.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     osc_tick,
  input  logic                     ale_off,
  input  logic                     fetch_req,
  input  logic [ADDR_W-1:0]        fetch_addr,
  input  logic                     dmem_req,
  input  logic                     dmem_we,
  input  logic [ADDR_W-1:0]        dmem_addr,
  input  logic [DATA_W-1:0]        dmem_wdata,
  input  logic [DATA_W-1:0]        p0_in,
  output logic                     fetch_ack,
  output logic                     dmem_ack,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        p0_out,
  output logic                     p0_oe,
  output logic [ADDR_W-DATA_W-1:0] p2_out,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rdata_vld
);

  localparam int SLOT = 6;
  localparam int PH_W = $clog2(2 * SLOT);
  localparam logic [PH_W-1:0] P_ALE_END  = PH_W'(2);
  localparam logic [PH_W-1:0] P_ADR_LAST = PH_W'(2);
  localparam logic [PH_W-1:0] P_PS_ON    = PH_W'(3);
  localparam logic [PH_W-1:0] P_WD_ON    = PH_W'(4);
  localparam logic [PH_W-1:0] P_STB_ON   = PH_W'(5);
  localparam logic [PH_W-1:0] P_STB_OFF  = PH_W'(10);
  localparam logic [PH_W-1:0] P_CODE_END = PH_W'(SLOT - 1);
  localparam logic [PH_W-1:0] P_DATA_END = PH_W'(2 * SLOT - 1);

  typedef enum logic [1:0] {K_IDLE, K_FETCH, K_RD, K_WR} kind_e;

  kind_e                    kind;
  logic [PH_W-1:0]          ph;
  logic [DATA_W-1:0]        alo, wd;
  logic [ADDR_W-DATA_W-1:0] ahi;
  logic                     ale_en;

  wire is_data = (kind == K_RD) || (kind == K_WR);
  wire last    = (ph == (is_data ? P_DATA_END : P_CODE_END));
  wire start   = osc_tick && last;
  wire capture = ((kind == K_FETCH) && (ph == P_CODE_END)) ||
                 ((kind == K_RD) && (ph == P_STB_OFF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind      <= K_IDLE;
      ph        <= P_CODE_END;
      alo       <= '0;
      ahi       <= '0;
      wd        <= '0;
      ale_en    <= 1'b0;
      fetch_ack <= 1'b0;
      dmem_ack  <= 1'b0;
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      fetch_ack <= start && fetch_req && !dmem_req;
      dmem_ack  <= start && dmem_req;
      rdata_vld <= osc_tick && capture;
      if (osc_tick && capture) rdata <= p0_in;
      if (start) begin
        ph     <= '0;
        ale_en <= !ale_off;
        if (dmem_req) begin
          kind <= dmem_we ? K_WR : K_RD;
          alo  <= dmem_addr[DATA_W-1:0];
          ahi  <= dmem_addr[ADDR_W-1:DATA_W];
          wd   <= dmem_wdata;
        end else if (fetch_req) begin
          kind <= K_FETCH;
          alo  <= fetch_addr[DATA_W-1:0];
          ahi  <= fetch_addr[ADDR_W-1:DATA_W];
        end else begin
          kind <= K_IDLE;
        end
      end else if (osc_tick) begin
        ph <= ph + PH_W'(1);
      end
    end
  end

  assign ale    = (ph < P_ALE_END) && ((kind != K_IDLE) || ale_en);
  assign psen_n = !((kind == K_FETCH) && (ph >= P_PS_ON));
  assign rd_n   = !((kind == K_RD) && (ph >= P_STB_ON) && (ph <= P_STB_OFF));
  assign wr_n   = !((kind == K_WR) && (ph >= P_STB_ON) && (ph <= P_STB_OFF));
  assign p0_oe  = (kind == K_WR) ||
                  (((kind == K_FETCH) || (kind == K_RD)) && (ph <= P_ADR_LAST));
  assign p0_out = ((kind == K_WR) && (ph >= P_WD_ON)) ? wd : alo;
  assign p2_out = ahi;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1); // R9
  AST_PORT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !p0_oe); // R4
  AST_ALE_QUIET_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n || !wr_n) |-> !ale); // R6
  AST_HIGH_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((!psen_n || !rd_n || !wr_n) && $past(!psen_n || !rd_n || !wr_n)) |-> $stable(p2_out)); // R8
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> p0_oe); // R5
  AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_ack, dmem_ack})); // R10
  AST_CAPTURE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_vld |-> $past(!psen_n || !rd_n)); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(osc_tick) |-> ($stable(ale) && $stable(psen_n) && $stable(rd_n) && $stable(wr_n) && !rdata_vld)); // R11

endmodule

// File: tb/ext_bus_seq_bench.sv
module ext_bus_seq_bench;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int HW = AW - DW;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0, ale_off = 1'b0;
  logic fetch_req = 1'b0, dmem_req = 1'b0, dmem_we = 1'b0;
  logic [AW-1:0] fetch_addr = '0, dmem_addr = '0;
  logic [DW-1:0] dmem_wdata = '0, p0_in = '0;
  logic fetch_ack, dmem_ack, ale, psen_n, rd_n, wr_n, p0_oe, rdata_vld;
  logic [DW-1:0] p0_out, rdata;
  logic [HW-1:0] p2_out;

  ext_bus_seq #(.DATA_W(DW), .ADDR_W(AW)) u_ext_bus_seq (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ale_off(ale_off),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .p0_in(p0_in),
    .fetch_ack(fetch_ack), .dmem_ack(dmem_ack), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe),
    .p2_out(p2_out), .rdata(rdata), .rdata_vld(rdata_vld));

  always #5 clk = ~clk;

  typedef struct {
    bit ale, psen_n, rd_n, wr_n, oe, cap, data, acc;
    logic [DW-1:0] p0;
    logic [HW-1:0] p2;
    int tag;
  } ent_t;

  ent_t q[$];
  ent_t cur;
  logic [HW-1:0] p2_last = '0;
  bit e_fack, e_dack, e_rv, last_tick, tick_mode, seen_f, seen_d;
  logic [DW-1:0] e_rd;
  int tests = 0, fails = 0, cycn = 0, wd_cnt = 0;

  task automatic chk(input bit ok, input int r, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // per-tick expectation of one slot or data access
  task automatic push_op(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit quiet);
    int n = (kind >= 2) ? 12 : 6;
    for (int t = 0; t < n; t++) begin
      ent_t e;
      e.acc = (kind != 0);
      e.data = (kind >= 2);
      e.ale = (t < 2) && (kind != 0 || !quiet);
      e.psen_n = !(kind == 1 && t >= 3);
      e.rd_n = !(kind == 2 && t >= 5 && t <= 10);
      e.wr_n = !(kind == 3 && t >= 5 && t <= 10);
      e.oe = (kind == 3) || ((kind == 1 || kind == 2) && t <= 2);
      e.p0 = (kind == 3 && t >= 4) ? d : a[DW-1:0];
      e.p2 = (kind != 0) ? a[AW-1:DW] : p2_last;
      e.cap = (kind == 1 && t == 5) || (kind == 2 && t == 10);
      case (kind)
        0: e.tag = quiet ? 7 : 2;
        1: e.tag = 3;
        2: e.tag = (t < 6) ? 4 : 6;
        default: e.tag = (t < 6) ? 5 : 6;
      endcase
      q.push_back(e);
    end
    if (kind != 0) p2_last = a[AW-1:DW];
  endtask

  task automatic predict();
    e_fack = 0; e_dack = 0; e_rv = 0;
    last_tick = osc_tick;
    if (osc_tick) begin
      if (cur.cap) begin e_rv = 1; e_rd = p0_in; end
      if (q.size() == 0) begin
        if (dmem_req) begin
          e_dack = 1;
          push_op(dmem_we ? 3 : 2, dmem_addr, dmem_wdata, ale_off);
        end else if (fetch_req) begin
          e_fack = 1;
          push_op(1, fetch_addr, '0, ale_off);
        end else begin
          push_op(0, '0, '0, ale_off);
        end
      end
      cur = q.pop_front();
    end
  endtask

  task automatic compare();
    int t = last_tick ? cur.tag : 11;
    chk(ale == cur.ale, t, "ale", ale, cur.ale);
    chk(psen_n == cur.psen_n, cur.data ? 9 : t, "psen_n", psen_n, cur.psen_n);
    chk(rd_n == cur.rd_n, t, "rd_n", rd_n, cur.rd_n);
    chk(wr_n == cur.wr_n, t, "wr_n", wr_n, cur.wr_n);
    chk(p0_oe == cur.oe, t, "p0_oe", p0_oe, cur.oe);
    if (cur.oe) chk(p0_out == cur.p0, t, "p0_out", p0_out, cur.p0);
    chk(p2_out == cur.p2, cur.acc ? 8 : t, "p2_out", p2_out, cur.p2);
    chk(fetch_ack == e_fack, 10, "fetch_ack", fetch_ack, e_fack);
    chk(dmem_ack == e_dack, 10, "dmem_ack", dmem_ack, e_dack);
    chk(rdata_vld == e_rv, t, "rdata_vld", rdata_vld, e_rv);
    if (e_rv) chk(rdata == e_rd, t, "rdata", rdata, e_rd);
    if (fetch_ack) seen_f = 1;
    if (dmem_ack) seen_d = 1;
  endtask

  task automatic step();
    cycn++;
    osc_tick = tick_mode ? ((cycn % 3) != 2) : 1'b1;
    p0_in = DW'(cycn * 29 + 7);
    predict();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_fetch(input logic [AW-1:0] a);
    fetch_req = 1; fetch_addr = a; seen_f = 0;
    while (!seen_f) step();
    fetch_req = 0;
  endtask

  task automatic do_data(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    dmem_req = 1; dmem_we = we; dmem_addr = a; dmem_wdata = d; seen_d = 0;
    while (!seen_d) step();
    dmem_req = 0;
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt == LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", wd_cnt);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cur = '{ale: 0, psen_n: 1, rd_n: 1, wr_n: 1, oe: 0, cap: 0, data: 0, acc: 0,
            p0: '0, p2: '0, tag: 1};
    last_tick = 1; tick_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare();                              // R1 reset state
    idle(30);                               // R2 free-running ALE
    do_fetch(16'h12A5);                     // R3 fetch
    do_fetch(16'h3C5A);
    do_fetch(16'hFF00);
    do_fetch(16'h00FF);
    idle(8);
    do_data(0, 16'h8F3C, 8'h00);            // R4 read, R6 skipped pulse
    do_data(1, 16'h40C7, 8'h5A);            // R5 write, R9 psen idle
    do_data(1, 16'hA5A5, 8'hFF);
    do_data(0, 16'h0102, 8'h00);            // R8 high byte
    idle(14);
    ale_off = 1;                            // R7 quiet idle, ALE kept for accesses
    idle(20);
    do_fetch(16'h7E81);
    do_data(0, 16'hC3E1, 8'h00);
    do_data(1, 16'h1234, 8'hA6);
    idle(20);
    ale_off = 0;
    idle(12);
    fetch_req = 1; fetch_addr = 16'h2468;   // R10 data wins over fetch
    dmem_req = 1; dmem_we = 1; dmem_addr = 16'h9BDF; dmem_wdata = 8'h3C;
    seen_f = 0; seen_d = 0;
    while (!seen_d) step();
    dmem_req = 0;
    while (!seen_f) step();
    fetch_req = 0;
    idle(10);
    tick_mode = 1;                          // R11 gaps between oscillator ticks
    do_fetch(16'h5555);
    do_data(1, 16'hAAAA, 8'hC9);
    do_data(0, 16'h6E6E, 8'h00);
    ale_off = 1;
    idle(30);
    ale_off = 0;
    idle(30);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule